// File: doc/BRIEF.md
# Tick Timer with Period Match Modes

This block is a core-local tick timer. A count register advances by one on every cycle in which the `tick` enable is high. In a real system `tick` is a fixed-rate strobe, nominally one every 50 ns (20 MHz). A control register holds a period, an interrupt enable, an interrupt pending flag and a two-bit mode. The timer checks for a match against the period only in the low period-width bits of the count. When a match occurs, the timer can raise an interrupt. It can also clear the count, halt, or keep running, depending on the mode.

Software reaches both registers through a single-cycle write port and a combinational read port. `wr_sel` and `rd_sel` choose between them: 0 selects the count and 1 selects the control word. Bit positions in the control word are given relative to the word width `CNT_W`. The mode occupies the top two bits, the interrupt enable sits one bit below the mode, the pending flag sits below the enable, and the period fills the low `PER_W` bits. Bits between the pending flag and the period read as zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 and `irq` is 0.
- R2: While the mode is non-zero and the timer is not halted, the count grows by exactly one on each clock cycle with `tick` high. The count does not change in any cycle with `tick` low.
- R3: A write with `wr_sel`=0 loads the count, and a write with `wr_sel`=1 loads the control word. A write takes priority over a tick in the same cycle. Unused control bits read back as 0.
- R4: A match occurs when the low `PER_W` bits of the incremented count equal the period. The count bits above `PER_W` play no part in the match.
- R5: If the masked count already sits at or above the period, the next match comes only after the masked field wraps through zero and climbs back to the period.
- R6: A match with the interrupt enable set sets the pending flag. The flag stays set until a control write loads it with 0. A match with the enable clear leaves the flag at 0.
- R7: `irq` is high exactly when both the pending flag and the enable are set.
- R8: In mode 01 (restart), the match cycle loads the count with 0 instead of the period value.
- R9: In mode 10 (one-shot), the count stops at the matched value and holds through later ticks. Any register write lets it count again.
- R10: In mode 11 (continuous), the count moves past the match value one step per tick.
- R11: In mode 00 (off), the count never advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 control |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 control |
| rd_data | output | CNT_W | Read data |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench builds the timer with `CNT_W`=16 and `PER_W`=4. This makes the control word 16 bits, with mode at 15:14, enable at 13, pending at 12 and period at 3:0. Bits 11:4 are padding, which exercises the zero-fill variant of the readback. With a 4-bit period field, a wrap of the masked count takes only 16 ticks. A starting count whose upper bits are non-zero then shows within a few cycles that those bits are left out of the match.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      TT_OFF     = 2'b00,
      TT_RESTART = 2'b01,
      TT_ONESHOT = 2'b10,
      TT_FREE    = 2'b11
   } tt_mode_e;
endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             set_pend,
   output tt_mode_e         mode,
   output logic             ien,
   output logic             pend,
   output logic [PER_W-1:0] period,
   output logic [CNT_W-1:0] word
);
   localparam int PAD_W = CNT_W - 4 - PER_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= TT_OFF;
         ien    <= 1'b0;
         pend   <= 1'b0;
         period <= '0;
      end else if (wr_en) begin
         mode   <= tt_mode_e'(wr_data[CNT_W-1 -: 2]);
         ien    <= wr_data[CNT_W-3];
         pend   <= wr_data[CNT_W-4];
         period <= wr_data[PER_W-1:0];
      end else if (set_pend) begin
         pend   <= 1'b1;
      end
   end

   generate
      if (PAD_W == 0) begin : g_packed
         assign word = {mode, ien, pend, period};
      end else begin : g_padded
         assign word = {mode, ien, pend, {PAD_W{1'b0}}, period};
      end
   endgenerate
endmodule

// File: rtl/tt_match.sv
module tt_match #(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [PER_W-1:0] period,
   output logic             hit
);
   assign hit = (cnt_next[PER_W-1:0] == period);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_any,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   input  tt_mode_e         mode,
   input  logic             hit,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_next,
   output logic             halted,
   output logic             step
);
   assign cnt_next = cnt_q + 1'b1;
   assign step     = tick && (mode != TT_OFF) && !halted && !wr_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         halted <= 1'b0;
      end else if (wr_any) begin
         if (wr_cnt) cnt_q <= wr_data;
         halted <= 1'b0;
      end else if (step) begin
         if (hit && mode == TT_RESTART) cnt_q <= '0;
         else                           cnt_q <= cnt_next;
         if (hit && mode == TT_ONESHOT) halted <= 1'b1;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq
);
   generate
      if (PER_W < 1 || PER_W > CNT_W - 4) begin : g_bad_width
         $error("tick_timer: PER_W must lie in 1..CNT_W-4");
      end
   endgenerate

   tt_mode_e         mode;
   logic             ien, pend, hit, step, halted, match_evt;
   logic [PER_W-1:0] period;
   logic [CNT_W-1:0] cnt_q, cnt_next, ctrl_word;

   assign match_evt = step && hit;

   tt_ctrl_reg #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_sel), .wr_data(wr_data),
      .set_pend(match_evt && ien), .mode(mode), .ien(ien), .pend(pend),
      .period(period), .word(ctrl_word)
   );

   tt_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
      .cnt_next(cnt_next), .period(period), .hit(hit)
   );

   tt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_any(wr_en), .wr_cnt(wr_en && !wr_sel),
      .wr_data(wr_data), .tick(tick), .mode(mode), .hit(hit),
      .cnt_q(cnt_q), .cnt_next(cnt_next), .halted(halted), .step(step)
   );

   assign rd_data = rd_sel ? ctrl_word : cnt_q;
   assign irq     = pend && ien;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [CNT_W-1:0] cnt,
   input tt_mode_e         mode,
   input logic             ien,
   input logic             pend,
   input logic             halted,
   input logic             match_evt
);
   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(cnt));
   // R11
   off_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TT_OFF && !wr_en) |=> $stable(cnt));
   // R8
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && mode == TT_RESTART) |=> (cnt == '0));
   // R9
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wr_en) |=> $stable(cnt));
   // R10
   free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && mode == TT_FREE) |=> (cnt == $past(cnt) + 1'b1));
   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && ien && !wr_en) |=> pend);
   // R6
   pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(wr_en && wr_sel));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_tick_timer_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
   .cnt(cnt_q), .mode(mode), .ien(ien), .pend(pend), .halted(halted),
   .match_evt(match_evt)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   localparam int CNT_W = 16;
   localparam int PER_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_sel = 1'b0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             rd_sel = 1'b0;
   logic [CNT_W-1:0] rd_data;
   logic             irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tick_timer #(.CNT_W(CNT_W), .PER_W(PER_W)) u_tick_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [15:0] cw(logic [1:0] m, logic ie, logic ip, logic [3:0] p);
      return {m, ie, ip, 8'h00, p};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic sel, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic rd(logic sel, output logic [15:0] v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(0, v); check("R1 count", v, 0);
      rd(1, v); check("R1 ctrl", v, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_off();
      logic [15:0] v;
      wr(1, cw(2'b00, 1, 0, 4'd8));
      wr(0, 16'd7);
      ticks(3);
      rd(0, v); check("R11 off mode holds", v, 7);
   endtask

   task automatic t_no_tick();
      logic [15:0] v;
      wr(1, cw(2'b11, 0, 0, 4'd9));
      wr(0, 16'd30);
      repeat (5) @(negedge clk);
      rd(0, v); check("R2 no tick holds", v, 30);
      ticks(3);
      rd(0, v); check("R2 one per tick", v, 33);
   endtask

   task automatic t_free();
      logic [15:0] v;
      wr(1, cw(2'b11, 1, 0, 4'd5));
      wr(0, 16'd0);
      ticks(4);
      check("R7 irq before match", irq, 0);
      ticks(1);
      rd(0, v); check("R4 count at match", v, 5);
      check("R7 irq after match", irq, 1);
      ticks(3);
      rd(0, v); check("R10 continuous past match", v, 8);
      rd(1, v); check("R6 pending held", v[12], 1);
      wr(1, cw(2'b11, 1, 0, 4'd5));
      check("R6 pending cleared by write", irq, 0);
   endtask

   task automatic t_no_ie();
      logic [15:0] v;
      wr(1, cw(2'b11, 0, 0, 4'd3));
      wr(0, 16'd0);
      ticks(4);
      rd(0, v); check("R10 count", v, 4);
      rd(1, v); check("R6 no pending without enable", v, 16'hC003);
      check("R7 irq low", irq, 0);
   endtask

   task automatic t_restart();
      logic [15:0] v;
      wr(1, cw(2'b01, 1, 0, 4'd4));
      wr(0, 16'd0);
      ticks(4);
      rd(0, v); check("R8 restart clears", v, 0);
      check("R6 pending on restart match", irq, 1);
      ticks(2);
      rd(0, v); check("R8 counts again", v, 2);
   endtask

   task automatic t_oneshot();
      logic [15:0] v;
      wr(1, cw(2'b10, 0, 0, 4'd3));
      wr(0, 16'd0);
      ticks(6);
      rd(0, v); check("R9 one-shot stops", v, 3);
      wr(0, 16'd10);
      ticks(2);
      rd(0, v); check("R9 write resumes", v, 12);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      wr(1, cw(2'b11, 1, 0, 4'd2));
      wr(0, 16'h0125);
      ticks(12);
      rd(0, v); check("R5 count before wrap match", v, 16'h0131);
      check("R5 no early match", irq, 0);
      ticks(1);
      rd(0, v); check("R4 count at wrapped match", v, 16'h0132);
      check("R4 upper bits ignored", irq, 1);
   endtask

   task automatic t_write_prio();
      logic [15:0] v;
      wr(1, cw(2'b11, 0, 0, 4'd0));
      wr(0, 16'd20);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd100;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd(0, v); check("R3 write beats tick", v, 100);
      wr(1, 16'hFFFF);
      rd(1, v); check("R3 unused bits read zero", v, 16'hF00F);
      check("R7 irq from written pending", irq, 1);
      wr(1, 16'h0000);
      check("R7 irq low after clear", irq, 0);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_off();
      t_no_tick();
      t_free();
      t_no_ie();
      t_restart();
      t_oneshot();
      t_wrap();
      t_write_prio();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule